// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

This peripheral gives software control over 32 general-purpose pins through a small word-addressed register bus. Reads are combinational. A write takes effect at the clock edge where select and write are both high. Each pin has an input enable, an output enable, an output value and an output invert bit. A pin drives the value bit XORed with the invert bit. The output enable is brought out as its own vector, so a pad can tri-state any pin whose enable is clear.

Each pin input first passes through a two-flop synchronizer. The synchronized level is masked by the input enable. The masked level feeds the input value register and four detectors: level high, level low, rising edge and falling edge. Each detector sets a sticky pending flag per pin, whatever the enable registers hold. Writing a 1 to a pending bit clears it. If the condition is still present on the same edge, the flag sets again. Each of the four pending types has its own enable register. A pin's interrupt output is the OR, over the four types, of pending AND enable.

The register offsets are as follows. Reads of any other offset, including misaligned ones, return zero.

| Register | Offset |
|---|---|
| Input value (read only) | 0x00 |
| Input enable | 0x04 |
| Output enable | 0x08 |
| Output value | 0x0C |
| Rise enable | 0x18 |
| Rise pending | 0x1C |
| Fall enable | 0x20 |
| Fall pending | 0x24 |
| High enable | 0x28 |
| High pending | 0x2C |
| Low enable | 0x30 |
| Low pending | 0x34 |
| Output invert | 0x40 |

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every register reads zero, and `pin_out`, `pin_oe` and `pin_irq` are all zero.
- R2: The input value register (0x00) reads the synchronized pin level ANDed with the input enable (0x04). A pin change first shows in a read after the second rising clock edge.
- R3: `pin_out` equals the output value register (0x0C) XORed with the output invert register (0x40).
- R4: `pin_oe` equals the output enable register (0x08).
- R5: The high pending flag (0x2C) sets while an input-enabled synchronized pin is 1. The low pending flag (0x34) sets while it is 0. A pin whose input enable is clear never sets a pending flag.
- R6: The rise pending flag (0x1C) sets when an enabled synchronized pin goes from 0 to 1. The fall pending flag (0x24) sets when it goes from 1 to 0.
- R7: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. A condition present on the clearing edge sets the bit again.
- R8: Pending flags update regardless of the enable registers (0x18, 0x20, 0x28, 0x30), and writing an enable leaves the pending bits unchanged.
- R9: `pin_irq[i]` is the OR over the four types of pending[i] AND enable[i].
- R10: Unmapped or misaligned offsets read zero. Writes to them and to the input value register change no register.
- R11: A write strobe with `bus_sel` low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears every register |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 32 | Raw pin levels, asynchronous |
| pin_out | output | 32 | Value driven on each pin |
| pin_oe | output | 32 | Per-pin driver enable |
| pin_irq | output | 32 | Per-pin interrupt request |

## Verification
The bench reads the input value one and two edges after a pin change. A design with a missing or extra synchronizer stage fails that check. It changes enabled and disabled pins together, so a design that ignores the mask sets rise or fall flags on the low half. It clears a level flag while the level persists, to show that the set condition wins over the clear. A design that lets the clear win, or that treats a written 0 as a clear, reads a different pending value. It also writes enables over existing pending bits and compares `pin_irq` pin by pin, which exposes a wrong AND/OR combination or an enable write that disturbs the pending bits.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned GP_KINDS  = 4;
    localparam int unsigned KIND_RISE = 0;
    localparam int unsigned KIND_FALL = 1;
    localparam int unsigned KIND_HIGH = 2;
    localparam int unsigned KIND_LOW  = 3;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_IN,
        SEL_IEN,
        SEL_OEN,
        SEL_OVAL,
        SEL_RISE_IE,
        SEL_RISE_IP,
        SEL_FALL_IE,
        SEL_FALL_IP,
        SEL_HIGH_IE,
        SEL_HIGH_IP,
        SEL_LOW_IE,
        SEL_LOW_IP,
        SEL_OXOR
    } gpio_reg_e;

    function automatic gpio_reg_e gp_decode(input logic [7:0] off);
        gpio_reg_e r;
        case (off)
            8'h00:   r = SEL_IN;
            8'h04:   r = SEL_IEN;
            8'h08:   r = SEL_OEN;
            8'h0C:   r = SEL_OVAL;
            8'h18:   r = SEL_RISE_IE;
            8'h1C:   r = SEL_RISE_IP;
            8'h20:   r = SEL_FALL_IE;
            8'h24:   r = SEL_FALL_IP;
            8'h28:   r = SEL_HIGH_IE;
            8'h2C:   r = SEL_HIGH_IP;
            8'h30:   r = SEL_LOW_IE;
            8'h34:   r = SEL_LOW_IP;
            8'h40:   r = SEL_OXOR;
            default: r = SEL_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= din;
            for (int i = 1; i < int'(STAGES); i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_pend.sv
module gpio_pend
    import gpio_pkg::*;
#(
    parameter int unsigned NPIN = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NPIN-1:0]                lvl,
    input  logic [NPIN-1:0]                ien,
    input  logic [GP_KINDS-1:0][NPIN-1:0]  clr,
    input  logic [GP_KINDS-1:0][NPIN-1:0]  ie,
    output logic [GP_KINDS-1:0][NPIN-1:0]  pend,
    output logic [NPIN-1:0]                irq
);
    logic [NPIN-1:0]               prev_q;
    logic [GP_KINDS-1:0][NPIN-1:0] set_v;
    logic [GP_KINDS-1:0][NPIN-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    always_comb begin
        set_v[KIND_RISE] =  lvl & ~prev_q & ien;
        set_v[KIND_FALL] = ~lvl &  prev_q & ien;
        set_v[KIND_HIGH] =  lvl & ien;
        set_v[KIND_LOW]  = ~lvl & ien;
    end

    for (genvar k = 0; k < GP_KINDS; k++) begin : g_kind
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q[k] <= '0;
            else        pend_q[k] <= (pend_q[k] & ~clr[k]) | set_v[k];
        end

        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (pend_q[k] & $past(clr[k]) & ~$past(set_v[k])) == '0); // R7
        AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (($past(pend_q[k]) & ~pend_q[k]) & ~$past(clr[k])) == '0); // R7
    end

    always_comb begin
        irq = '0;
        for (int k = 0; k < int'(GP_KINDS); k++) begin
            irq = irq | (pend_q[k] & ie[k]);
        end
    end

    assign pend = pend_q;

    AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q[KIND_RISE] & ~$past(pend_q[KIND_RISE]))
                  & ~$past(lvl & ~prev_q & ien)) == '0); // R6
    AST_LOW_NEEDS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q[KIND_LOW] & ~$past(pend_q[KIND_LOW])) & ~$past(ien)) == '0); // R5
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int unsigned NPIN   = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  gpio_reg_e                      sel,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [NPIN-1:0]                in_val,
    input  logic [GP_KINDS-1:0][NPIN-1:0]  pend,
    output logic [NPIN-1:0]                ien,
    output logic [NPIN-1:0]                oen,
    output logic [NPIN-1:0]                oval,
    output logic [NPIN-1:0]                oxor,
    output logic [GP_KINDS-1:0][NPIN-1:0]  ie,
    output logic [GP_KINDS-1:0][NPIN-1:0]  clr,
    output logic [DATA_W-1:0]              rdata
);
    logic [NPIN-1:0]               wd;
    logic [NPIN-1:0]               ien_q, oen_q, oval_q, oxor_q;
    logic [GP_KINDS-1:0][NPIN-1:0] ie_q;
    logic [NPIN-1:0]               rd;

    assign wd = wdata[NPIN-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q  <= '0;
            oen_q  <= '0;
            oval_q <= '0;
            oxor_q <= '0;
            ie_q   <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_IEN:     ien_q  <= wd;
                SEL_OEN:     oen_q  <= wd;
                SEL_OVAL:    oval_q <= wd;
                SEL_OXOR:    oxor_q <= wd;
                SEL_RISE_IE: ie_q[KIND_RISE] <= wd;
                SEL_FALL_IE: ie_q[KIND_FALL] <= wd;
                SEL_HIGH_IE: ie_q[KIND_HIGH] <= wd;
                SEL_LOW_IE:  ie_q[KIND_LOW]  <= wd;
                default: ;
            endcase
        end
    end

    always_comb begin
        clr = '0;
        if (wr_en) begin
            case (sel)
                SEL_RISE_IP: clr[KIND_RISE] = wd;
                SEL_FALL_IP: clr[KIND_FALL] = wd;
                SEL_HIGH_IP: clr[KIND_HIGH] = wd;
                SEL_LOW_IP:  clr[KIND_LOW]  = wd;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd = '0;
        case (sel)
            SEL_IN:      rd = in_val;
            SEL_IEN:     rd = ien_q;
            SEL_OEN:     rd = oen_q;
            SEL_OVAL:    rd = oval_q;
            SEL_OXOR:    rd = oxor_q;
            SEL_RISE_IE: rd = ie_q[KIND_RISE];
            SEL_FALL_IE: rd = ie_q[KIND_FALL];
            SEL_HIGH_IE: rd = ie_q[KIND_HIGH];
            SEL_LOW_IE:  rd = ie_q[KIND_LOW];
            SEL_RISE_IP: rd = pend[KIND_RISE];
            SEL_FALL_IP: rd = pend[KIND_FALL];
            SEL_HIGH_IP: rd = pend[KIND_HIGH];
            SEL_LOW_IP:  rd = pend[KIND_LOW];
            default:     rd = '0;
        endcase
        rdata = '0;
        rdata[NPIN-1:0] = rd;
    end

    assign ien  = ien_q;
    assign oen  = oen_q;
    assign oval = oval_q;
    assign oxor = oxor_q;
    assign ie   = ie_q;

    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(oval_q) && $stable(oen_q) && $stable(ien_q)
                   && $stable(oxor_q) && $stable(ie_q)); // R11
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int unsigned NPIN        = 32,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic [NPIN-1:0]   pin_irq
);
    localparam int unsigned OFF_W = 8;

    logic                          hi_zero;
    gpio_reg_e                     sel;
    logic                          wr_en;
    logic [NPIN-1:0]               lvl, in_val;
    logic [NPIN-1:0]               ien, oen, oval, oxor;
    logic [GP_KINDS-1:0][NPIN-1:0] ie, clr, pend;

    if (ADDR_W > OFF_W) begin : g_hi
        assign hi_zero = ~|bus_addr[ADDR_W-1:OFF_W];
    end else begin : g_nohi
        assign hi_zero = 1'b1;
    end

    assign sel    = (bus_sel && hi_zero) ? gp_decode(bus_addr[OFF_W-1:0]) : SEL_NONE;
    assign wr_en  = bus_sel && bus_we;
    assign in_val = lvl & ien;

    gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (lvl)
    );

    gpio_regfile #(.NPIN(NPIN), .DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .sel   (sel),
        .wdata (bus_wdata),
        .in_val(in_val),
        .pend  (pend),
        .ien   (ien),
        .oen   (oen),
        .oval  (oval),
        .oxor  (oxor),
        .ie    (ie),
        .clr   (clr),
        .rdata (bus_rdata)
    );

    gpio_pend #(.NPIN(NPIN)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl),
        .ien  (ien),
        .clr  (clr),
        .ie   (ie),
        .pend (pend),
        .irq  (pin_irq)
    );

    assign pin_out = oval ^ oxor;
    assign pin_oe  = oen;

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_irq & ~((pend[KIND_RISE] & ie[KIND_RISE]) | (pend[KIND_FALL] & ie[KIND_FALL])
                   | (pend[KIND_HIGH] & ie[KIND_HIGH]) | (pend[KIND_LOW] & ie[KIND_LOW]))) == '0); // R9
endmodule

// File: tb/sim_gpio_ctrl.sv
module sim_gpio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe, pin_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [7:0] A_IN = 8'h00, A_IEN = 8'h04, A_OEN = 8'h08, A_OVAL = 8'h0C,
                           A_RIE = 8'h18, A_RIP = 8'h1C, A_FIE = 8'h20, A_FIP = 8'h24,
                           A_HIE = 8'h28, A_HIP = 8'h2C, A_LIE = 8'h30, A_LIP = 8'h34,
                           A_XOR = 8'h40;

    always #2.5 clk = ~clk;

    gpio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_irq(pin_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(tag, d, exp);
    endtask

    task automatic t_reset;
        logic [7:0] addrs [13] = '{A_IN, A_IEN, A_OEN, A_OVAL, A_RIE, A_RIP, A_FIE,
                                   A_FIP, A_HIE, A_HIP, A_LIE, A_LIP, A_XOR};
        for (int i = 0; i < 13; i++) expect_reg("R1 reg after reset", addrs[i], 32'h0);
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 pin_irq", pin_irq, 32'h0);
    endtask

    task automatic t_outputs;
        bus_write(A_OVAL, 32'hA5A5A5A5);
        check("R3 pin_out value only", pin_out, 32'hA5A5A5A5);
        bus_write(A_OEN, 32'hFFFF00F0);
        check("R4 pin_oe", pin_oe, 32'hFFFF00F0);
        expect_reg("R4 readback", A_OEN, 32'hFFFF00F0);
        bus_write(A_XOR, 32'hFF00FF00);
        check("R3 pin_out inverted", pin_out, 32'h5AA55AA5);
    endtask

    task automatic t_inputs;
        pin_in = 32'h5A5AC3C3;
        repeat (3) @(negedge clk);
        expect_reg("R2 masked with no enable", A_IN, 32'h0);
        expect_reg("R5 no high flag on disabled pins", A_HIP, 32'h0);
        bus_write(A_IEN, 32'hFFFF0000);
        expect_reg("R2 masked read", A_IN, 32'h5A5A0000);
        @(negedge clk);
        pin_in = 32'h0F0FC3C3;
        expect_reg("R2 one edge later still old", A_IN, 32'h5A5A0000);
        expect_reg("R2 two edges later new", A_IN, 32'h0F0F0000);
        pin_in = 32'h5A5AC3C3;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_pending;
        bus_write(A_RIP, 32'hFFFFFFFF);
        bus_write(A_FIP, 32'hFFFFFFFF);
        bus_write(A_HIP, 32'hFFFFFFFF);
        bus_write(A_LIP, 32'hFFFFFFFF);
        expect_reg("R5 high level", A_HIP, 32'h5A5A0000);
        expect_reg("R5 low level", A_LIP, 32'hA5A50000);
        expect_reg("R6 no rise while stable", A_RIP, 32'h0);
        expect_reg("R6 no fall while stable", A_FIP, 32'h0);
        @(negedge clk);
        pin_in = 32'h5BAA3C3C;
        repeat (4) @(negedge clk);
        expect_reg("R6 rise edges", A_RIP, 32'h01A00000);
        expect_reg("R6 fall edges", A_FIP, 32'h00500000);
        expect_reg("R5 high accumulates", A_HIP, 32'h5BFA0000);
        expect_reg("R5 low accumulates", A_LIP, 32'hA5F50000);
        bus_write(A_RIP, 32'h0);
        expect_reg("R7 zero write keeps", A_RIP, 32'h01A00000);
        bus_write(A_RIP, 32'h00200000);
        expect_reg("R7 one clears bit", A_RIP, 32'h01800000);
        bus_write(A_HIP, 32'hFFFFFFFF);
        expect_reg("R7 level re-sets after clear", A_HIP, 32'h5BAA0000);
    endtask

    task automatic t_irq;
        check("R9 no irq without enable", pin_irq, 32'h0);
        bus_write(A_RIE, 32'h00800000);
        expect_reg("R8 enable keeps rise pending", A_RIP, 32'h01800000);
        check("R9 rise irq", pin_irq, 32'h00800000);
        bus_write(A_HIE, 32'h00010000);
        check("R9 high enabled but not pending", pin_irq, 32'h00800000);
        bus_write(A_LIE, 32'h00010000);
        check("R9 low irq adds", pin_irq, 32'h00810000);
        expect_reg("R8 low pending unchanged", A_LIP, 32'hA5F50000);
        bus_write(A_RIP, 32'hFFFFFFFF);
        check("R9 rise cleared", pin_irq, 32'h00010000);
        bus_write(A_LIE, 32'h0);
        check("R9 low disabled", pin_irq, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [7:0] holes [6] = '{8'h10, 8'h14, 8'h38, 8'h3C, 8'h44, 8'h06};
        for (int i = 0; i < 6; i++) expect_reg("R10 unmapped reads zero", holes[i], 32'h0);
        bus_write(A_IN, 32'hFFFFFFFF);
        expect_reg("R10 input reg not writable", A_IN, 32'h5BAA0000);
        bus_write(8'h44, 32'hFFFFFFFF);
        bus_write(8'h0E, 32'hFFFFFFFF);
        expect_reg("R10 oval kept", A_OVAL, 32'hA5A5A5A5);
        expect_reg("R10 oen kept", A_OEN, 32'hFFFF00F0);
        expect_reg("R10 ien kept", A_IEN, 32'hFFFF0000);
        check("R10 pin_out kept", pin_out, 32'h5AA55AA5);
    endtask

    task automatic t_unselected;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b1; bus_addr = A_OVAL; bus_wdata = 32'h0;
        @(negedge clk);
        bus_addr = A_OEN;
        @(negedge clk);
        bus_we = 1'b0;
        check("R11 pin_out unchanged", pin_out, 32'h5AA55AA5);
        check("R11 pin_oe unchanged", pin_oe, 32'hFFFF00F0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_outputs();
        t_inputs();
        t_pending();
        t_irq();
        t_unmapped();
        t_unselected();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule